// File: doc/BRIEF.md
# Write-Back Write-Allocate Cache Sequencer

This block is the control sequencer for a set-associative, write-back, write-allocate data cache. It sits between a CPU request port and a block-wide main-memory port. It issues commands to the cache storage array, which sits outside this block along with the tag comparators and the memory. A request carries a valid flag, a direction bit, a word address and a write word. The sequencer registers the request and holds it for as long as the request is in flight. It asks the array for a lookup and reads back the array's hit and dirty-victim flags. From these it chooses one of three paths: serve the hit at once; fetch the missing block straight away; or first write the dirty victim back and then fetch.

The path for a miss always ends in a fill cycle. In that cycle the fetched block is written into the array and the replacement state is touched. The CPU access is also completed in that cycle: for a read miss the requested word is read out, and for a write miss the CPU word is merged into the new line. Memory transfers wait on an acknowledge, so any memory latency is tolerated. Completion is signalled to the CPU by a single-cycle done pulse.

Top module: `wbwa_cache_seq`

## Requirements
- R1: After a synchronous active-low reset the sequencer is idle: every array command, both memory requests and `cpu_done` are low. They stay low for as long as `req_valid` is low.
- R2: A request is taken when `req_valid` is high in an idle cycle. In the next cycle `arr_lookup` is high for exactly one cycle. The captured fields are presented on `arr_tag`, `arr_index`, `arr_offset` and `arr_wdata` until done, whatever the request inputs then do. The offset is the lowest `OFF_W` address bits, the index is the next `IDX_W` bits, and the tag is the remaining upper bits.
- R3: In the lookup cycle, if `arr_hit` is high, the sequencer asserts `arr_touch` together with `arr_rd_word` (for `req_write`=0) or `arr_wr_word` (for `req_write`=1). No memory request follows, whatever `arr_victim_dirty` says.
- R4: On a miss with `arr_victim_dirty` high, `mem_wr_req` is held high until the first cycle in which `mem_ack` is high. During that time `mem_blk_addr` is {victim tag sampled in the lookup cycle, index}. The cycle after the acknowledge starts the block fetch.
- R5: On a miss with a clean victim, and after a write-back has finished, `mem_rd_req` is held high with `mem_blk_addr` = {request tag, index} until the first cycle in which `mem_ack` is high.
- R6: The cycle after the fetch is acknowledged is a single fill cycle in which `arr_refill` and `arr_touch` are high. For a read, `arr_rd_word` is also high in that cycle.
- R7: For a write miss, the fill cycle asserts `arr_wr_word` as well, so the CPU word is merged into the refilled line.
- R8: `cpu_done` is a one-cycle pulse. It comes in the cycle after a lookup hit, or in the cycle after the fill cycle, and in that cycle the sequencer is idle and may take a new request.
- R9: `mem_rd_req` and `mem_wr_req` are never high together, and `arr_rd_word` and `arr_wr_word` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 0 read, 1 write |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Write word |
| arr_hit | input | 1 | Array reports a tag match in the set |
| arr_victim_dirty | input | 1 | Array reports the chosen victim is dirty |
| arr_victim_tag | input | ADDR_W-OFF_W-IDX_W | Tag of the chosen victim |
| mem_ack | input | 1 | Memory completes the current transfer |
| arr_lookup | output | 1 | Lookup command |
| arr_rd_word | output | 1 | Read the addressed word to the CPU |
| arr_wr_word | output | 1 | Write the CPU word and mark dirty |
| arr_refill | output | 1 | Write the fetched block into the victim way |
| arr_touch | output | 1 | Update replacement state for the set |
| arr_tag | output | ADDR_W-OFF_W-IDX_W | Held request tag |
| arr_index | output | IDX_W | Held request index |
| arr_offset | output | OFF_W | Held request word offset |
| arr_wdata | output | WORD_W | Held write word |
| mem_rd_req | output | 1 | Block fetch request |
| mem_wr_req | output | 1 | Block write-back request |
| mem_blk_addr | output | ADDR_W-OFF_W | Block address for the memory transfer |
| cpu_done | output | 1 | Request complete pulse |

## Verification
The bench builds the sequencer with an 8-bit address, a 2-bit offset, a 2-bit index and an 8-bit word. With a 4-bit tag, every address field and block address can be predicted and checked arithmetically. Under that configuration it sweeps every combination of direction, hit and victim-dirty flag against write-back and fetch acknowledge latencies of zero to two cycles. This covers an acknowledge in the very first request cycle as well as longer waits. After each request is taken, the request inputs and the victim tag are scrambled, which shows that the captured values are what drive the array and memory.

// File: rtl/cc_pkg.sv
// Package: shared state and command types for the cache sequencer.
// Assumes: one request in flight at a time.
package cc_pkg;

    typedef enum logic [2:0] {
        CS_IDLE   = 3'd0,
        CS_LOOKUP = 3'd1,
        CS_EVICT  = 3'd2,
        CS_FETCH  = 3'd3,
        CS_FILL   = 3'd4
    } cc_state_e;

    typedef struct packed {
        logic lookup;
        logic rd_word;
        logic wr_word;
        logic refill;
        logic touch;
        logic mem_rd;
        logic mem_wr;
    } cc_cmd_t;

endpackage

// File: rtl/cc_req_hold.sv
// Module: cc_req_hold
// Registers the CPU request on acceptance and splits the address into
// tag, index and word offset. Holds them until the next acceptance.
// Assumes: capture is asserted only in an idle cycle with a valid request.
module cc_req_hold #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            capture,
    input  logic                            req_write,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [WORD_W-1:0]               req_wdata,
    output logic                            is_write,
    output logic [ADDR_W-OFF_W-IDX_W-1:0]   tag,
    output logic [IDX_W-1:0]                idx,
    output logic [OFF_W-1:0]                off,
    output logic [WORD_W-1:0]               wdata
);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [ADDR_W-1:0] addr_q;

    // Capture the request fields when the sequencer accepts a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata    <= '0;
            is_write <= 1'b0;
        end else if (capture) begin
            addr_q   <= req_addr;
            wdata    <= req_wdata;
            is_write <= req_write;
        end
    end

    // Split the held address: offset low, index middle, tag high.
    always_comb begin
        off = addr_q[OFF_W-1:0];
        idx = addr_q[OFF_W +: IDX_W];
        tag = addr_q[ADDR_W-1 -: TAG_W];
    end

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable({addr_q, wdata, is_write})); // R2

endmodule

// File: rtl/cc_seq.sv
// Module: cc_seq
// Request sequencer FSM: idle, lookup, write-back, fetch, fill. Produces
// the capture strobe and the registered done pulse.
// Assumes: the array's hit and dirty flags are valid in the lookup cycle.
module cc_seq
    import cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      arr_hit,
    input  logic      arr_victim_dirty,
    input  logic      mem_ack,
    output cc_state_e state,
    output logic      capture,
    output logic      done
);
    cc_state_e state_nx;

    // Accept a new request only from the idle state.
    always_comb capture = (state == CS_IDLE) && req_valid;

    // Next-state selection for the request path.
    always_comb begin
        state_nx = state;
        unique case (state)
            CS_IDLE:   if (req_valid) state_nx = CS_LOOKUP;
            CS_LOOKUP: begin
                if (arr_hit)               state_nx = CS_IDLE;
                else if (arr_victim_dirty) state_nx = CS_EVICT;
                else                       state_nx = CS_FETCH;
            end
            CS_EVICT:  if (mem_ack) state_nx = CS_FETCH;
            CS_FETCH:  if (mem_ack) state_nx = CS_FILL;
            CS_FILL:   state_nx = CS_IDLE;
            default:   state_nx = CS_IDLE;
        endcase
    end

    // State register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CS_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= ((state == CS_LOOKUP) && arr_hit) || (state == CS_FILL);
        end
    end

    AST_ACCEPT_TO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (state == CS_LOOKUP)); // R2
    AST_EVICT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_EVICT) && !mem_ack |=> (state == CS_EVICT)); // R4
    AST_FETCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_FETCH) && !mem_ack |=> (state == CS_FETCH)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == CS_IDLE)); // R8

endmodule

// File: rtl/cc_cmd_dec.sv
// Module: cc_cmd_dec
// Decodes the sequencer state into array and memory commands. Keeps the
// victim tag seen on a miss, which forms the write-back block address.
// Assumes: the victim tag input is valid in the lookup cycle only.
module cc_cmd_dec
    import cc_pkg::*;
#(
    parameter int TAG_W = 25,
    parameter int IDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cc_state_e               state,
    input  logic                    arr_hit,
    input  logic                    is_write,
    input  logic [TAG_W-1:0]        req_tag,
    input  logic [IDX_W-1:0]        req_idx,
    input  logic [TAG_W-1:0]        victim_tag_in,
    output cc_cmd_t                 cmd,
    output logic [TAG_W+IDX_W-1:0]  mem_blk_addr
);
    logic [TAG_W-1:0] victim_q;
    logic             hit_now;
    logic             fill_now;

    // Keep the victim tag from the lookup cycle of a miss.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  victim_q <= '0;
        else if ((state == CS_LOOKUP) && !arr_hit)   victim_q <= victim_tag_in;
    end

    // Command decode: hit service, write-back, fetch, fill with merge.
    always_comb begin
        hit_now      = (state == CS_LOOKUP) && arr_hit;
        fill_now     = (state == CS_FILL);
        cmd.lookup   = (state == CS_LOOKUP);
        cmd.rd_word  = (hit_now || fill_now) && !is_write;
        cmd.wr_word  = (hit_now || fill_now) &&  is_write;
        cmd.refill   = fill_now;
        cmd.touch    = hit_now || fill_now;
        cmd.mem_wr   = (state == CS_EVICT);
        cmd.mem_rd   = (state == CS_FETCH);
    end

    // Block address: victim line during write-back, request line otherwise.
    always_comb begin
        if (state == CS_EVICT) mem_blk_addr = {victim_q, req_idx};
        else                   mem_blk_addr = {req_tag,  req_idx};
    end

    AST_VICTIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_EVICT) |=> $stable(victim_q)); // R4

endmodule

// File: rtl/wbwa_cache_seq.sv
// Module: wbwa_cache_seq
// Top of the write-back write-allocate cache sequencer. It ties the
// request register, the FSM and the command decoder together.
// Assumes: the storage array and memory sit outside; memory transfers end
// on a one-cycle mem_ack during a request.
module wbwa_cache_seq
    import cc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [WORD_W-1:0]             req_wdata,
    input  logic                          arr_hit,
    input  logic                          arr_victim_dirty,
    input  logic [ADDR_W-OFF_W-IDX_W-1:0] arr_victim_tag,
    input  logic                          mem_ack,
    output logic                          arr_lookup,
    output logic                          arr_rd_word,
    output logic                          arr_wr_word,
    output logic                          arr_refill,
    output logic                          arr_touch,
    output logic [ADDR_W-OFF_W-IDX_W-1:0] arr_tag,
    output logic [IDX_W-1:0]              arr_index,
    output logic [OFF_W-1:0]              arr_offset,
    output logic [WORD_W-1:0]             arr_wdata,
    output logic                          mem_rd_req,
    output logic                          mem_wr_req,
    output logic [ADDR_W-OFF_W-1:0]       mem_blk_addr,
    output logic                          cpu_done
);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    cc_state_e state;
    logic      capture;
    logic      is_write;
    cc_cmd_t   cmd;

    cc_req_hold #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .is_write  (is_write),
        .tag       (arr_tag),
        .idx       (arr_index),
        .off       (arr_offset),
        .wdata     (arr_wdata)
    );

    cc_seq i_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .arr_hit          (arr_hit),
        .arr_victim_dirty (arr_victim_dirty),
        .mem_ack          (mem_ack),
        .state            (state),
        .capture          (capture),
        .done             (cpu_done)
    );

    cc_cmd_dec #(
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) i_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .arr_hit       (arr_hit),
        .is_write      (is_write),
        .req_tag       (arr_tag),
        .req_idx       (arr_index),
        .victim_tag_in (arr_victim_tag),
        .cmd           (cmd),
        .mem_blk_addr  (mem_blk_addr)
    );

    // Drive the command outputs from the decoded command.
    always_comb begin
        arr_lookup  = cmd.lookup;
        arr_rd_word = cmd.rd_word;
        arr_wr_word = cmd.wr_word;
        arr_refill  = cmd.refill;
        arr_touch   = cmd.touch;
        mem_rd_req  = cmd.mem_rd;
        mem_wr_req  = cmd.mem_wr;
    end

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R9
    AST_WORD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_rd_word && arr_wr_word)); // R9
    AST_EVICT_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && mem_ack |=> mem_rd_req); // R4
    AST_FETCH_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_ack |=> arr_refill); // R6
    AST_FILL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_refill |=> cpu_done); // R8
    AST_LOOKUP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_lookup |=> !arr_lookup); // R2

endmodule

// File: tb/test_wbwa_cache_seq.sv
module test_wbwa_cache_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int WORD_W = 8;
    localparam int OFF_W  = 2;
    localparam int IDX_W  = 2;
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic arr_hit = 1'b0;
    logic arr_victim_dirty = 1'b0;
    logic [TAG_W-1:0] arr_victim_tag = '0;
    logic mem_ack = 1'b0;
    logic arr_lookup, arr_rd_word, arr_wr_word, arr_refill, arr_touch;
    logic [TAG_W-1:0] arr_tag;
    logic [IDX_W-1:0] arr_index;
    logic [OFF_W-1:0] arr_offset;
    logic [WORD_W-1:0] arr_wdata;
    logic mem_rd_req, mem_wr_req;
    logic [ADDR_W-OFF_W-1:0] mem_blk_addr;
    logic cpu_done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbwa_cache_seq #(
        .ADDR_W (ADDR_W), .WORD_W (WORD_W), .OFF_W (OFF_W), .IDX_W (IDX_W)
    ) i_wbwa_cache_seq (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .arr_hit (arr_hit),
        .arr_victim_dirty (arr_victim_dirty), .arr_victim_tag (arr_victim_tag),
        .mem_ack (mem_ack), .arr_lookup (arr_lookup), .arr_rd_word (arr_rd_word),
        .arr_wr_word (arr_wr_word), .arr_refill (arr_refill), .arr_touch (arr_touch),
        .arr_tag (arr_tag), .arr_index (arr_index), .arr_offset (arr_offset),
        .arr_wdata (arr_wdata), .mem_rd_req (mem_rd_req), .mem_wr_req (mem_wr_req),
        .mem_blk_addr (mem_blk_addr), .cpu_done (cpu_done)
    );

    // Observed order: lookup, rd, wr, refill, touch, mem_rd, mem_wr, done
    function automatic logic [7:0] obs();
        return {arr_lookup, arr_rd_word, arr_wr_word, arr_refill, arr_touch,
                mem_rd_req, mem_wr_req, cpu_done};
    endfunction

    task automatic chk_cmd(string rq, logic [7:0] exp);
        n_run++;
        if (obs() !== exp) begin
            n_fail++;
            $display("FAIL %s commands: got %b expected %b at %0t", rq, obs(), exp, $time);
        end
    endtask

    task automatic chk_val(string rq, string what, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
        end
    endtask

    // Held-field check; tag upper, index middle, offset low (R2).
    task automatic chk_fields(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
        chk_val("R2", "tag",    int'(arr_tag),    int'(a[7:4]));
        chk_val("R2", "index",  int'(arr_index),  int'(a[3:2]));
        chk_val("R2", "offset", int'(arr_offset), int'(a[1:0]));
        chk_val("R2", "wdata",  int'(arr_wdata),  int'(d));
    endtask

    task automatic run_txn(bit w, bit h, bit d, int lw, int la,
                           logic [ADDR_W-1:0] a, logic [WORD_W-1:0] dat,
                           logic [TAG_W-1:0] vt);
        @(negedge clk);
        arr_hit = h; arr_victim_dirty = d; arr_victim_tag = vt;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = dat;
        @(negedge clk);
        // lookup cycle; scramble request inputs (R2)
        req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = ~dat;
        chk_cmd(h ? "R3" : "R2", {1'b1, h & ~w, h & w, 1'b0, h, 1'b0, 1'b0, 1'b0});
        chk_fields(a, dat);
        if (!h) begin
            if (d) begin
                for (int k = 0; k <= lw; k++) begin
                    @(negedge clk);
                    arr_victim_tag = ~vt;          // victim tag must be the captured one
                    chk_cmd("R4", 8'b0000_0010);
                    chk_val("R4", "wb addr", int'(mem_blk_addr), int'({vt, a[3:2]}));
                    mem_ack = (k == lw);
                end
            end
            for (int k = 0; k <= la; k++) begin
                @(negedge clk);
                mem_ack = 1'b0;
                chk_cmd("R5", 8'b0000_0100);
                chk_val("R5", "fetch addr", int'(mem_blk_addr), int'(a[7:2]));
                chk_fields(a, dat);
                mem_ack = (k == la);
            end
            @(negedge clk);
            mem_ack = 1'b0;
            chk_cmd(w ? "R7" : "R6", {1'b0, ~w, w, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
            chk_fields(a, dat);
        end
        @(negedge clk);
        chk_cmd("R8", 8'b0000_0001);
        @(negedge clk);
        chk_cmd("R8", 8'b0000_0000);
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_cmd("R1", 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req_addr = 8'(i * 29 + 3);
            arr_hit = i[0];
            chk_cmd("R1", 8'h00);
        end
        n = 0;
        for (int w = 0; w < 2; w++)
            for (int h = 0; h < 2; h++)
                for (int d = 0; d < 2; d++)
                    for (int lw = 0; lw < 3; lw++)
                        for (int la = 0; la < 3; la++) begin
                            run_txn(w[0], h[0], d[0], lw, la, 8'(n * 37 + 11),
                                    8'(n * 53 + 5), 4'(n * 7 + 3));
                            n++;
                        end
        // R9 exclusivity observed across the whole sweep through chk_cmd patterns
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule